// File: doc/BRIEF.md
# Dual-Clock FIFO with Latched Read Timing Mode

This block is a first-in first-out buffer whose write port and read port run on two clocks with no relation to each other. Words written on the write clock are held in an internal array and handed out in the same order on the read clock. The write and read positions are exchanged between the two clock domains as Gray-coded counters passed through chains of synchronizer flops. Every flag is computed pessimistically, so a full or empty condition is never reported late.

The read timing is chosen once per master reset. The level of `fwft_sel` while `mrst_n` is low decides the mode, and that choice holds until the next reset. In standard mode a word reaches `rd_data` only through an explicit read. In fall-through mode the oldest word moves to `rd_data` by itself, and a read removes it so the next word can take its place. The two status outputs change meaning with the mode. In standard mode they report empty and full. In fall-through mode they report that a head word is ready and that there is room for input.

Half-full, almost-empty and almost-full are produced in both modes. The two almost thresholds are set by separate offset inputs. A chip select, sampled on the read clock, gates the read enable. Together with the output enable, the chip select forms a flag that tells whether the output is being driven.

Top module: `dcfifo_modal`

## Requirements
- R1: Every accepted write is returned exactly once, in write order, while the write and read clocks run at unrelated rates. Each write-side Gray pointer step changes at most one bit.
- R2: Standard mode (mode 0). A word moves to `rd_data` at the read-clock edge where `rd_en_n`=0, `rd_cs_n`=0 and `empty_rdy`=0. A stored word does not appear on `rd_data` unless such a read happens, and `rd_data` resets to 0.
- R3: Fall-through mode (mode 1). The first word written into an empty FIFO appears on `rd_data`, with `empty_rdy`=1, exactly at the third read-clock rising edge after the write edge. No read enable is needed for this.
- R4: Fall-through mode. While `empty_rdy`=1, the head word stays on `rd_data` until a read-clock edge with `rd_en_n`=0 and `rd_cs_n`=0. That edge consumes the head and loads the next word, if there is one.
- R5: The mode is captured from `fwft_sel` on read-clock edges while `mrst_n`=0. Changes on `fwft_sel` after reset has been released have no effect.
- R6: `empty_rdy` means empty in mode 0 and head word ready in mode 1. `full_rdy` means full in mode 0 and room for input in mode 1. After reset: mode 0 gives `empty_rdy`=1 and `full_rdy`=0; mode 1 gives `empty_rdy`=0 and `full_rdy`=1.
- R7: With `rd_cs_n`=1 at a read-clock edge, the read enable is ignored at that edge. `rd_drive` is 1 only when `rd_cs_n` was 0 at the last read-clock edge and `out_en_n`=0.
- R8: `almost_empty`=1 when the read-side word count is at most `ae_off`. In mode 1 this count includes the word presented on `rd_data`.
- R9: `almost_full`=1 when the write-side word count is at least DEPTH − `af_off`.
- R10: `half_full`=1 when the write-side word count is greater than DEPTH/2. It is valid in both modes, and full implies both half-full and almost-full.
- R11: A write while full and a read while empty are ignored, and neither pointer moves.
- R12: Full is reported at the write edge that fills the last slot. Empty (mode 0), or not-ready (mode 1), is reported at the read edge that takes the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous to both domains |
| fwft_sel | input | 1 | Mode select sampled during reset: 0 standard, 1 fall-through |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | DW | Write data |
| rd_en_n | input | 1 | Read enable, active low |
| rd_cs_n | input | 1 | Read chip select, active low, sampled on rd_clk |
| out_en_n | input | 1 | Output enable, active low |
| ae_off | input | AW | Almost-empty offset |
| af_off | input | AW | Almost-full offset |
| rd_data | output | DW | Read data |
| rd_drive | output | 1 | 1 when the output is considered driven |
| empty_rdy | output | 1 | Empty (mode 0) or head ready (mode 1) |
| full_rdy | output | 1 | Full (mode 0) or input room (mode 1) |
| half_full | output | 1 | Count above half of depth |
| almost_empty | output | 1 | Count at or below `ae_off` |
| almost_full | output | 1 | Count at or above DEPTH − `af_off` |

## Verification
The bench builds the block with DW=8 and AW=3, which gives a depth of eight words. At that size the bench can walk every fill level from one to full, read at every step which flag thresholds are crossed (with offsets of 2 for both almost flags), and wrap the pointers several times within a short run. The small depth also lets fall-through mode hold nine words, eight in the array and one on the output. This brings the input-ready drop and the half-full flag under that mode within a handful of writes. The write and read clocks have periods of 7 ns and 5 ns with a phase offset, so their edges never coincide. This makes the three-edge fall-through latency exact and repeatable.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] gray_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            stg_q[0] <= gray_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign gray_s = stg_q[STAGES-1];

    // binary bit i is the parity of gray bits i and above
    for (genvar i = 0; i < W; i++) begin : g_g2b
        assign bin_o[i] = ^(gray_s >> i);
    end

endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we_i) cells[waddr_i] <= wdata_i;
    end

    assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic [AW:0]   rbin_sync_i,
    input  logic [AW-1:0] af_off_i,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [AW:0]   wgray_o,
    output logic          full_o,
    output logic          half_o,
    output logic          afull_o
);
    localparam logic [AW:0] FULL_CNT = {1'b1, {AW{1'b0}}};
    localparam logic [AW:0] HALF_CNT = FULL_CNT >> 1;

    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
        logic        full;
        logic        half;
        logic        afull;
    } wr_state_t;

    wr_state_t   st_d, st_q;
    logic        accept;
    logic [AW:0] level;
    logic [AW:0] af_mark;

    always_comb begin
        st_d    = st_q;
        accept  = !wr_en_n && !st_q.full;
        st_d.bin  = st_q.bin + {{AW{1'b0}}, accept};
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        // synchronized read position lags, so the level can only read high
        level   = st_d.bin - rbin_sync_i;
        af_mark = FULL_CNT - {1'b0, af_off_i};
        st_d.full  = (level == FULL_CNT);
        st_d.half  = (level > HALF_CNT);
        st_d.afull = (level >= af_mark);
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign we_o    = accept;
    assign waddr_o = st_q.bin[AW-1:0];
    assign wgray_o = st_q.gray;
    assign full_o  = st_q.full;
    assign half_o  = st_q.half;
    assign afull_o = st_q.afull;

endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl import dcf_pkg::*; #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          mode_sel_i,
    input  logic          rd_en_n,
    input  logic          rd_cs_n,
    input  logic [AW:0]   wbin_sync_i,
    input  logic [AW-1:0] ae_off_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [AW-1:0] raddr_o,
    output logic [AW:0]   rgray_o,
    output logic [DW-1:0] dout_o,
    output logic          head_valid_o,
    output logic          empty_o,
    output logic          aempty_o,
    output logic          cs_o,
    output logic          fwft_o
);
    typedef struct packed {
        logic [AW:0]   bin;
        logic [AW:0]   gray;
        logic [DW-1:0] dout;
        logic          head;
        logic          empty;
        logic          aempty;
        logic          cs;
    } rd_state_t;

    rd_state_t st_d, st_q;
    rd_mode_e  mode_q;
    logic      fwft;
    logic      ren;
    logic      avail;
    logic      take;
    logic      pop;
    logic [AW:0] stored;
    logic [AW:0] level;

    // mode is captured only while master reset is held
    always_ff @(posedge rd_clk) begin
        if (!rst_n) mode_q <= mode_sel_i ? MODE_FWFT : MODE_STD;
    end

    assign fwft = (mode_q == MODE_FWFT);

    always_comb begin
        st_d    = st_q;
        ren     = !rd_en_n && !rd_cs_n;
        avail   = (wbin_sync_i != st_q.bin);
        take    = 1'b0;
        pop     = 1'b0;
        st_d.cs = !rd_cs_n;
        if (!fwft) begin
            if (ren && !st_q.empty) begin
                pop       = 1'b1;
                st_d.dout = mem_rdata_i;
            end
        end else begin
            take = ren && st_q.head;
            if ((!st_q.head || take) && avail) begin
                pop       = 1'b1;
                st_d.dout = mem_rdata_i;
                st_d.head = 1'b1;
            end else if (take) begin
                st_d.head = 1'b0;
            end
        end
        st_d.bin  = st_q.bin + {{AW{1'b0}}, pop};
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        // synchronized write position lags, so the level can only read low
        stored = wbin_sync_i - st_d.bin;
        level  = stored + {{AW{1'b0}}, fwft && st_d.head};
        st_d.empty  = (stored == '0);
        st_d.aempty = (level <= {1'b0, ae_off_i});
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.empty  <= 1'b1;
            st_q.aempty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr_o      = st_q.bin[AW-1:0];
    assign rgray_o      = st_q.gray;
    assign dout_o       = st_q.dout;
    assign head_valid_o = st_q.head;
    assign empty_o      = st_q.empty;
    assign aempty_o     = st_q.aempty;
    assign cs_o         = st_q.cs;
    assign fwft_o       = fwft;

endmodule

// File: rtl/dcfifo_modal.sv
module dcfifo_modal import dcf_pkg::*; #(
    parameter int DW          = 16,
    parameter int AW          = 4,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          mrst_n,
    input  logic          fwft_sel,
    input  logic          wr_en_n,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en_n,
    input  logic          rd_cs_n,
    input  logic          out_en_n,
    input  logic [AW-1:0] ae_off,
    input  logic [AW-1:0] af_off,
    output logic [DW-1:0] rd_data,
    output logic          rd_drive,
    output logic          empty_rdy,
    output logic          full_rdy,
    output logic          half_full,
    output logic          almost_empty,
    output logic          almost_full
);
    localparam int PW = AW + 1;

    logic          w_we;
    logic [AW-1:0] w_addr;
    logic [PW-1:0] w_gray;
    logic          w_full;
    logic [PW-1:0] w_rbin;
    logic [AW-1:0] r_addr;
    logic [PW-1:0] r_gray;
    logic [PW-1:0] r_wbin;
    logic [DW-1:0] r_mem;
    logic          r_head;
    logic          r_empty;
    logic          r_cs;
    logic          mode_fwft;

    dcf_store #(.DW(DW), .AW(AW)) u_store (
        .wr_clk  (wr_clk),
        .we_i    (w_we),
        .waddr_i (w_addr),
        .wdata_i (wr_data),
        .raddr_i (r_addr),
        .rdata_o (r_mem)
    );

    dcf_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk    (wr_clk),
        .rst_n  (mrst_n),
        .gray_i (r_gray),
        .bin_o  (w_rbin)
    );

    dcf_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk    (rd_clk),
        .rst_n  (mrst_n),
        .gray_i (w_gray),
        .bin_o  (r_wbin)
    );

    dcf_wr_ctl #(.AW(AW)) u_wr (
        .wr_clk      (wr_clk),
        .rst_n       (mrst_n),
        .wr_en_n     (wr_en_n),
        .rbin_sync_i (w_rbin),
        .af_off_i    (af_off),
        .we_o        (w_we),
        .waddr_o     (w_addr),
        .wgray_o     (w_gray),
        .full_o      (w_full),
        .half_o      (half_full),
        .afull_o     (almost_full)
    );

    dcf_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
        .rd_clk       (rd_clk),
        .rst_n        (mrst_n),
        .mode_sel_i   (fwft_sel),
        .rd_en_n      (rd_en_n),
        .rd_cs_n      (rd_cs_n),
        .wbin_sync_i  (r_wbin),
        .ae_off_i     (ae_off),
        .mem_rdata_i  (r_mem),
        .raddr_o      (r_addr),
        .rgray_o      (r_gray),
        .dout_o       (rd_data),
        .head_valid_o (r_head),
        .empty_o      (r_empty),
        .aempty_o     (almost_empty),
        .cs_o         (r_cs),
        .fwft_o       (mode_fwft)
    );

    // the mode bit is static after reset, so its use on the write side is safe
    assign empty_rdy = mode_fwft ? r_head  : r_empty;
    assign full_rdy  = mode_fwft ? !w_full : w_full;
    assign rd_drive  = r_cs && !out_en_n;

endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en_n,
    input logic          rd_en_n,
    input logic          rd_cs_n,
    input logic          w_full,
    input logic [AW:0]   w_gray,
    input logic          half_full,
    input logic          almost_full,
    input logic          fwft,
    input logic          r_empty,
    input logic          r_head,
    input logic [AW:0]   r_gray,
    input logic [DW-1:0] rd_data
);

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (w_full && !wr_en_n) |=> $stable(w_gray)); // R11

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!fwft && r_empty && !rd_en_n) |=> ($stable(r_gray) && $stable(rd_data))); // R11

    AST_CS_GATES_READ: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!fwft && rd_cs_n) |=> ($stable(r_gray) && $stable(rd_data))); // R7

    AST_MODE_HELD: assert property (@(posedge rd_clk) disable iff (!rst_n)
        1'b1 |=> $stable(fwft)); // R5

    AST_HEAD_HELD: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (fwft && r_head && (rd_en_n || rd_cs_n)) |=> (r_head && $stable(rd_data))); // R4

    AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
        1'b1 |=> ($countones(w_gray ^ $past(w_gray)) <= 1)); // R1

    AST_FULL_IMPLIES_LEVELS: assert property (@(posedge wr_clk) disable iff (!rst_n)
        w_full |-> (half_full && almost_full)); // R10

endmodule

bind dcfifo_modal dcf_checker #(.DW(DW), .AW(AW)) u_chk (
    .wr_clk      (wr_clk),
    .rd_clk      (rd_clk),
    .rst_n       (mrst_n),
    .wr_en_n     (wr_en_n),
    .rd_en_n     (rd_en_n),
    .rd_cs_n     (rd_cs_n),
    .w_full      (w_full),
    .w_gray      (w_gray),
    .half_full   (half_full),
    .almost_full (almost_full),
    .fwft        (mode_fwft),
    .r_empty     (r_empty),
    .r_head      (r_head),
    .r_gray      (r_gray),
    .rd_data     (rd_data)
);

// File: tb/sim_dcfifo_modal.sv
`timescale 1ns/100ps
module sim_dcfifo_modal;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          mrst_n = 1'b0;
    logic          fwft_sel = 1'b0;
    logic          wr_en_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_n = 1'b1;
    logic          rd_cs_n = 1'b0;
    logic          out_en_n = 1'b0;
    logic [AW-1:0] ae_off = 3'd2;
    logic [AW-1:0] af_off = 3'd2;
    logic [DW-1:0] rd_data;
    logic          rd_drive, empty_rdy, full_rdy, half_full, almost_empty, almost_full;

    int  errors = 0;
    int  checks = 0;
    bit  fwft_mode = 1'b0;
    bit  rd_pend = 1'b0;
    logic [DW-1:0] exp_q [$];

    // 200 MHz read clock; write clock at 7 ns, offset so edges never meet
    always #2.5 rd_clk = ~rd_clk;
    initial begin
        #1.3;
        forever #3.5 wr_clk = ~wr_clk;
    end

    dcfifo_modal #(.DW(DW), .AW(AW)) u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .fwft_sel(fwft_sel),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n), .rd_cs_n(rd_cs_n),
        .out_en_n(out_en_n), .ae_off(ae_off), .af_off(af_off), .rd_data(rd_data),
        .rd_drive(rd_drive), .empty_rdy(empty_rdy), .full_rdy(full_rdy),
        .half_full(half_full), .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver side of the scoreboard: accepted writes enter the queue
    always @(negedge wr_clk) begin
        if (mrst_n && !wr_en_n && (fwft_mode ? full_rdy : !full_rdy))
            exp_q.push_back(wr_data);
    end

    // monitor side: reads are matched against the queue
    always @(negedge rd_clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) chk("R2 read without stored word", 1, 0);
            else chk("R1 R2 order", int'(rd_data), int'(exp_q.pop_front()));
        end
        rd_pend = 1'b0;
        if (mrst_n && !rd_en_n && !rd_cs_n) begin
            if (!fwft_mode && !empty_rdy) rd_pend = 1'b1;
            else if (fwft_mode && empty_rdy) begin
                if (exp_q.size() == 0) chk("R4 head without stored word", 1, 0);
                else chk("R1 R4 head", int'(rd_data), int'(exp_q.pop_front()));
            end
        end
    end

    task automatic wait_rd(input int n);
        repeat (n) @(posedge rd_clk);
        #1;
    endtask

    task automatic settle();
        repeat (5) @(posedge wr_clk);
        repeat (5) @(posedge rd_clk);
        #1;
    endtask

    task automatic put(input logic [DW-1:0] d);
        @(posedge wr_clk); #1;
        wr_en_n = 1'b0;
        wr_data = d;
        @(posedge wr_clk); #1;
        wr_en_n = 1'b1;
    endtask

    task automatic take();
        @(posedge rd_clk); #1;
        rd_en_n = 1'b0;
        @(posedge rd_clk); #1;
        rd_en_n = 1'b1;
    endtask

    task automatic do_reset(input bit mode);
        mrst_n = 1'b0;
        fwft_sel = mode;
        fwft_mode = mode;
        wr_en_n = 1'b1;
        rd_en_n = 1'b1;
        rd_cs_n = 1'b0;
        exp_q.delete();
        repeat (4) @(posedge rd_clk);
        repeat (2) @(posedge wr_clk);
        #1 mrst_n = 1'b1;
        #1 fwft_sel = !mode;   // later changes must not matter (R5)
        wait_rd(2);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // ---------------- standard mode ----------------
        do_reset(1'b0);
        chk("R6 reset empty", empty_rdy, 1);
        chk("R6 reset full", full_rdy, 0);
        chk("R10 reset half", half_full, 0);
        chk("R8 reset almost empty", almost_empty, 1);
        chk("R9 reset almost full", almost_full, 0);
        chk("R2 reset data", rd_data, 0);
        chk("R7 drive with cs", rd_drive, 1);

        // R2 and R5: no fall-through although the select moved to 1
        put(8'h11);
        settle();
        chk("R2 R5 no fall-through", rd_data, 0);
        chk("R6 not empty", empty_rdy, 0);
        chk("R8 one word", almost_empty, 1);
        take();
        chk("R12 empty at last read", empty_rdy, 1);

        // fill level by level
        for (int i = 0; i < DEPTH; i++) begin
            put(8'h40 + 8'(i));
            if (i == DEPTH - 1) chk("R12 full at filling write", full_rdy, 1);
            settle();
            chk("R10 half level", half_full, int'(i + 1 > DEPTH / 2));
            chk("R9 almost full level", almost_full, int'(i + 1 >= DEPTH - 2));
            chk("R8 almost empty level", almost_empty, int'(i + 1 <= 2));
            chk("R6 full level", full_rdy, int'(i + 1 == DEPTH));
        end

        // R11: write while full is dropped
        put(8'hEE);
        settle();
        chk("R11 still full", full_rdy, 1);
        for (int i = 0; i < DEPTH; i++) take();
        wait_rd(2);
        chk("R11 drained", exp_q.size(), 0);
        chk("R6 empty after drain", empty_rdy, 1);

        // R11: read while empty is ignored
        @(posedge rd_clk); #1 rd_en_n = 1'b0;
        wait_rd(4);
        rd_en_n = 1'b1;
        chk("R11 data kept on empty read", rd_data, 8'h47);
        chk("R11 still empty", empty_rdy, 1);
        put(8'h5A);
        settle();
        take();
        wait_rd(2);
        chk("R11 pointer not skipped", exp_q.size(), 0);

        // R7: chip select gates the read enable
        put(8'h6B);
        settle();
        rd_cs_n = 1'b1;
        wait_rd(1);
        chk("R7 drive off", rd_drive, 0);
        rd_en_n = 1'b0;
        wait_rd(3);
        rd_en_n = 1'b1;
        chk("R7 data held", rd_data, 8'h5A);
        chk("R7 word kept", empty_rdy, 0);
        rd_cs_n = 1'b0;
        wait_rd(1);
        chk("R7 drive back", rd_drive, 1);
        out_en_n = 1'b1;
        #0.5;
        chk("R7 output enable", rd_drive, 0);
        out_en_n = 1'b0;
        take();
        wait_rd(2);
        chk("R7 word read later", exp_q.size(), 0);

        // ---------------- fall-through mode ----------------
        do_reset(1'b1);
        chk("R6 reset not ready", empty_rdy, 0);
        chk("R6 reset input room", full_rdy, 1);
        chk("R2 reset data", rd_data, 0);

        // R3: exactly three read edges after the write edge
        @(posedge wr_clk); #1;
        wr_en_n = 1'b0;
        wr_data = 8'h81;
        @(posedge wr_clk);
        fork
            begin #1 wr_en_n = 1'b1; end
        join_none
        for (int k = 1; k <= 3; k++) begin
            @(posedge rd_clk); #1;
            chk("R3 ready after edge", empty_rdy, int'(k == 3));
        end
        chk("R3 head data", rd_data, 8'h81);

        // R4: head held without read enable
        put(8'h82);
        put(8'h83);
        settle();
        chk("R4 head kept", rd_data, 8'h81);
        chk("R4 still ready", empty_rdy, 1);
        chk("R8 count includes head", almost_empty, 0);
        take();
        take();
        take();
        chk("R12 not ready at last read", empty_rdy, 0);
        chk("R4 all consumed", exp_q.size(), 0);

        // fill under fall-through: eight in the array plus the head
        for (int i = 0; i < DEPTH + 1; i++) put(8'h90 + 8'(i));
        settle();
        chk("R6 no input room", full_rdy, 0);
        chk("R10 half in fall-through", half_full, 1);
        put(8'hFF);
        for (int i = 0; i < DEPTH + 1; i++) take();
        wait_rd(2);
        chk("R11 drained fall-through", exp_q.size(), 0);
        chk("R6 not ready at end", empty_rdy, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule